// File: doc/BRIEF.md
# Three-to-Two Phase Converter

This block sits on both sides of a vector rotator. On the forward side it takes phase samples and turns them into an orthogonal direct/quadrature pair. That pair is the unrotated pair, and it is the block's forward output. On the inverse side it takes an already rotated orthogonal pair and spreads it back into three phases spaced 120 degrees apart. The two sides are independent streams. Each side is qualified by a single-cycle valid and has a fixed latency of two clocks.

A 2-bit format select chooses how the forward inputs are read:
- Two orthogonal inputs (cosine and sine), passed straight through.
- Three phase inputs.
- Two phase inputs, with the first phase rebuilt as the negative sum of the other two.

A small state machine (states FS_IDLE and FS_LOAD) decides when the format select is sampled. In FS_IDLE the select pin is decoded directly. Accepting a sample moves the machine to FS_LOAD, where the format held from the previous accepted sample is reused. A cycle with no forward sample returns the machine to FS_IDLE. Scaling uses 16 fractional bits and arithmetic right shifts, so every result rounds toward minus infinity.

Top module: `phase_conv`

## Requirements
- R1: While reset is asserted and after it is released, `dq_valid`, `abc_valid` and all data outputs are zero until a sample has passed through.
- R2: `dq_valid` is high exactly two clock cycles after a cycle with `fwd_valid` high, and low otherwise.
- R3: Format code 2'b01 (orthogonal): `d_out` equals `ph_a` and `q_out` equals `ph_s`. `ph_b` and `ph_c` have no effect.
- R4: Format code 2'b10 (three inputs): `d_out` = ((2·ph_a − ph_b − ph_c)·21845) >>> 16 and `q_out` = ((ph_b − ph_c)·37837) >>> 16. `ph_s` has no effect.
- R5: Format code 2'b11 (two inputs): the first phase is taken as −(ph_b + ph_c), and then the R4 formulas apply. `ph_a` and `ph_s` have no effect.
- R6: Format code 2'b00 behaves exactly like 2'b01.
- R7: The format select is sampled only in FS_IDLE, which means the previous cycle accepted no forward sample. A sample accepted in FS_LOAD uses the format of the previously accepted sample.
- R8: `abc_valid` is high exactly two cycles after `rot_valid`. Then `out_a` = `rot_d`, `out_b` = ((−rot_d·32768) − rot_q·56756) >>> 16, and `out_c` = ((−rot_d·32768) + rot_q·56756) >>> 16.
- R9: Forward and inverse samples presented in the same cycle are both converted, each with its own result and latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_valid | input | 1 | Forward sample present |
| fmt_sel | input | 2 | Input format select |
| ph_a | input | IN_W | Phase 1 or cosine input |
| ph_b | input | IN_W | Phase 2 input |
| ph_c | input | IN_W | Phase 3 input |
| ph_s | input | IN_W | Sine input (orthogonal format) |
| dq_valid | output | 1 | Forward result valid |
| d_out | output | IN_W+2 | Unrotated direct component |
| q_out | output | IN_W+2 | Unrotated quadrature component |
| rot_valid | input | 1 | Rotated pair present |
| rot_d | input | IN_W+2 | Rotated direct component |
| rot_q | input | IN_W+2 | Rotated quadrature component |
| abc_valid | output | 1 | Three-phase result valid |
| out_a | output | IN_W+3 | Phase 1 output |
| out_b | output | IN_W+3 | Phase 2 output |
| out_c | output | IN_W+3 | Phase 3 output |

## Verification
The forward conversion and the inverse conversion can both take a sample in the same clock cycle. The bench provokes this by driving `fwd_valid` and `rot_valid` together across several formats. It then judges each stream against its own scoreboard queue, so a result that goes missing, is crossed over, or is delayed on either side shows up as a mismatch. A second collision exists inside the forward path: a format change that arrives while a sample is already being loaded. The bench drives back-to-back samples with differing select codes and expects the held format to apply.

// File: rtl/phconv_pkg.sv
package phconv_pkg;
    typedef enum logic [1:0] {
        FMT_RSV  = 2'b00,
        FMT_ORTH = 2'b01,
        FMT_3W   = 2'b10,
        FMT_2W   = 2'b11
    } fmt_e;

    localparam int FRAC    = 16;
    localparam int K_THIRD = 21845;   // 1/3 in Q16
    localparam int K_RSQ3  = 37837;   // 1/sqrt(3) in Q16
    localparam int K_SQ3H  = 56756;   // sqrt(3)/2 in Q16
    localparam int K_WIDTH = 18;      // signed width holding any constant
endpackage

// File: rtl/ph_fwd_ctrl.sv
module ph_fwd_ctrl
    import phconv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [1:0] fmt_sel,
    output fmt_e       eff_fmt
);
    typedef enum logic {FS_IDLE, FS_LOAD} fst_e;

    fst_e state_q, state_d;
    fmt_e mode_q;
    fmt_e decoded;

    always_comb begin
        unique case (fmt_sel)
            2'b00, 2'b01: decoded = FMT_ORTH;
            2'b10:        decoded = FMT_3W;
            default:      decoded = FMT_2W;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        unique case (state_q)
            FS_IDLE: state_d = in_valid ? FS_LOAD : FS_IDLE;
            FS_LOAD: state_d = in_valid ? FS_LOAD : FS_IDLE;
            default: state_d = FS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            FS_IDLE: eff_fmt = decoded;
            FS_LOAD: eff_fmt = mode_q;
            default: eff_fmt = FMT_ORTH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= FMT_ORTH;
        else if (in_valid) mode_q <= eff_fmt;
    end

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_LOAD && in_valid) |=> $stable(mode_q)); // R7
    AST_NO_RSV_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (eff_fmt != FMT_RSV)); // R6
endmodule

// File: rtl/ph_fwd_prep.sv
module ph_fwd_prep
    import phconv_pkg::*;
#(
    parameter int IN_W = 16,
    localparam int SW  = IN_W + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  fmt_e                 eff_fmt,
    input  logic signed [IN_W-1:0] a,
    input  logic signed [IN_W-1:0] b,
    input  logic signed [IN_W-1:0] c,
    input  logic signed [IN_W-1:0] s,
    output logic                 s1_v,
    output logic                 s1_ortho,
    output logic signed [SW-1:0] s1_dsum,
    output logic signed [SW-1:0] s1_qsum
);
    logic signed [SW-1:0] ae, be, ce, se, a_use, dsum, qsum;
    logic ortho;

    always_comb begin
        ae = {{(SW-IN_W){a[IN_W-1]}}, a};
        be = {{(SW-IN_W){b[IN_W-1]}}, b};
        ce = {{(SW-IN_W){c[IN_W-1]}}, c};
        se = {{(SW-IN_W){s[IN_W-1]}}, s};
        a_use = ae;
        ortho = 1'b0;
        unique case (eff_fmt)
            FMT_2W:  a_use = -(be + ce);
            FMT_3W:  a_use = ae;
            default: ortho = 1'b1;
        endcase
        if (ortho) begin
            dsum = ae;
            qsum = se;
        end else begin
            dsum = (a_use <<< 1) - be - ce;
            qsum = be - ce;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v     <= 1'b0;
            s1_ortho <= 1'b0;
            s1_dsum  <= '0;
            s1_qsum  <= '0;
        end else begin
            s1_v <= in_valid;
            if (in_valid) begin
                s1_ortho <= ortho;
                s1_dsum  <= dsum;
                s1_qsum  <= qsum;
            end
        end
    end
endmodule

// File: rtl/ph_fwd_scale.sv
module ph_fwd_scale
    import phconv_pkg::*;
#(
    parameter int IN_W = 16,
    localparam int SW  = IN_W + 3,
    localparam int OW  = IN_W + 2,
    localparam int PW  = SW + K_WIDTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s1_v,
    input  logic                 s1_ortho,
    input  logic signed [SW-1:0] s1_dsum,
    input  logic signed [SW-1:0] s1_qsum,
    output logic                 dq_valid,
    output logic signed [OW-1:0] d_out,
    output logic signed [OW-1:0] q_out
);
    localparam logic [K_WIDTH-1:0] KD = K_WIDTH'(K_THIRD);
    localparam logic [K_WIDTH-1:0] KQ = K_WIDTH'(K_RSQ3);

    logic signed [PW-1:0] pd, pq;
    logic signed [OW-1:0] d_scl, q_scl;

    always_comb begin
        pd = {{K_WIDTH{s1_dsum[SW-1]}}, s1_dsum} * {{SW{1'b0}}, KD};
        pq = {{K_WIDTH{s1_qsum[SW-1]}}, s1_qsum} * {{SW{1'b0}}, KQ};
        d_scl = pd[FRAC+OW-1:FRAC];
        q_scl = pq[FRAC+OW-1:FRAC];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_valid <= 1'b0;
            d_out    <= '0;
            q_out    <= '0;
        end else begin
            dq_valid <= s1_v;
            if (s1_v) begin
                d_out <= s1_ortho ? s1_dsum[OW-1:0] : d_scl;
                q_out <= s1_ortho ? s1_qsum[OW-1:0] : q_scl;
            end
        end
    end

    AST_ORTHO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && s1_ortho) |=> (d_out == $past(s1_dsum[OW-1:0]))); // R3
endmodule

// File: rtl/ph_inv.sv
module ph_inv
    import phconv_pkg::*;
#(
    parameter int OW  = 18,
    localparam int AW = OW + 1,
    localparam int PW = OW + K_WIDTH + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rot_valid,
    input  logic signed [OW-1:0] rot_d,
    input  logic signed [OW-1:0] rot_q,
    output logic                 abc_valid,
    output logic signed [AW-1:0] out_a,
    output logic signed [AW-1:0] out_b,
    output logic signed [AW-1:0] out_c
);
    localparam logic [K_WIDTH-1:0] KS = K_WIDTH'(K_SQ3H);

    logic                 r1_v;
    logic signed [OW-1:0] r1_d;
    logic signed [PW-1:0] r1_dh, r1_mq;
    logic signed [PW-1:0] dh, mq, nb, nc;

    always_comb begin
        dh = {{(PW-OW-FRAC+1){rot_d[OW-1]}}, rot_d, {(FRAC-1){1'b0}}};
        mq = {{(PW-OW){rot_q[OW-1]}}, rot_q} * {{(PW-K_WIDTH){1'b0}}, KS};
        nb = -r1_dh - r1_mq;
        nc = -r1_dh + r1_mq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1_v  <= 1'b0;
            r1_d  <= '0;
            r1_dh <= '0;
            r1_mq <= '0;
        end else begin
            r1_v <= rot_valid;
            if (rot_valid) begin
                r1_d  <= rot_d;
                r1_dh <= dh;
                r1_mq <= mq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abc_valid <= 1'b0;
            out_a     <= '0;
            out_b     <= '0;
            out_c     <= '0;
        end else begin
            abc_valid <= r1_v;
            if (r1_v) begin
                out_a <= {r1_d[OW-1], r1_d};
                out_b <= nb[FRAC+AW-1:FRAC];
                out_c <= nc[FRAC+AW-1:FRAC];
            end
        end
    end

    AST_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !r1_v |=> $stable(out_a) && $stable(out_b) && $stable(out_c)); // R8
endmodule

// File: rtl/phase_conv.sv
module phase_conv
    import phconv_pkg::*;
#(
    parameter int IN_W = 16,
    localparam int OW  = IN_W + 2,
    localparam int AW  = OW + 1,
    localparam int SW  = IN_W + 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fwd_valid,
    input  logic [1:0]             fmt_sel,
    input  logic signed [IN_W-1:0] ph_a,
    input  logic signed [IN_W-1:0] ph_b,
    input  logic signed [IN_W-1:0] ph_c,
    input  logic signed [IN_W-1:0] ph_s,
    output logic                   dq_valid,
    output logic signed [OW-1:0]   d_out,
    output logic signed [OW-1:0]   q_out,
    input  logic                   rot_valid,
    input  logic signed [OW-1:0]   rot_d,
    input  logic signed [OW-1:0]   rot_q,
    output logic                   abc_valid,
    output logic signed [AW-1:0]   out_a,
    output logic signed [AW-1:0]   out_b,
    output logic signed [AW-1:0]   out_c
);
    fmt_e                 eff_fmt;
    logic                 s1_v, s1_ortho;
    logic signed [SW-1:0] s1_dsum, s1_qsum;

    ph_fwd_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(fwd_valid),
        .fmt_sel(fmt_sel), .eff_fmt(eff_fmt)
    );

    ph_fwd_prep #(.IN_W(IN_W)) u_prep (
        .clk(clk), .rst_n(rst_n), .in_valid(fwd_valid), .eff_fmt(eff_fmt),
        .a(ph_a), .b(ph_b), .c(ph_c), .s(ph_s),
        .s1_v(s1_v), .s1_ortho(s1_ortho), .s1_dsum(s1_dsum), .s1_qsum(s1_qsum)
    );

    ph_fwd_scale #(.IN_W(IN_W)) u_scale (
        .clk(clk), .rst_n(rst_n), .s1_v(s1_v), .s1_ortho(s1_ortho),
        .s1_dsum(s1_dsum), .s1_qsum(s1_qsum),
        .dq_valid(dq_valid), .d_out(d_out), .q_out(q_out)
    );

    ph_inv #(.OW(OW)) u_inv (
        .clk(clk), .rst_n(rst_n), .rot_valid(rot_valid),
        .rot_d(rot_d), .rot_q(rot_q),
        .abc_valid(abc_valid), .out_a(out_a), .out_b(out_b), .out_c(out_c)
    );

    AST_FWD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid == $past(fwd_valid, 2)); // R2
    AST_INV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        abc_valid == $past(rot_valid, 2)); // R8
    AST_INV_A_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        abc_valid |-> (out_a == {$past(rot_d[OW-1], 2), $past(rot_d, 2)})); // R8
    AST_ORTHO_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !$past(fwd_valid) && fmt_sel[1] == 1'b0)
        |=> ##1 (q_out == {{(OW-IN_W){$past(ph_s[IN_W-1], 2)}}, $past(ph_s, 2)})); // R3
endmodule

// File: tb/phase_conv_test.sv
module phase_conv_test;
    localparam int IN_W = 16;
    localparam int OW   = IN_W + 2;
    localparam int AW   = OW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fwd_valid = 1'b0;
    logic [1:0] fmt_sel = 2'b01;
    logic signed [IN_W-1:0] ph_a = '0, ph_b = '0, ph_c = '0, ph_s = '0;
    logic dq_valid;
    logic signed [OW-1:0] d_out, q_out;
    logic rot_valid = 1'b0;
    logic signed [OW-1:0] rot_d = '0, rot_q = '0;
    logic abc_valid;
    logic signed [AW-1:0] out_a, out_b, out_c;

    always #5 clk = ~clk;

    phase_conv #(.IN_W(IN_W)) uut (
        .clk(clk), .rst_n(rst_n), .fwd_valid(fwd_valid), .fmt_sel(fmt_sel),
        .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c), .ph_s(ph_s),
        .dq_valid(dq_valid), .d_out(d_out), .q_out(q_out),
        .rot_valid(rot_valid), .rot_d(rot_d), .rot_q(rot_q),
        .abc_valid(abc_valid), .out_a(out_a), .out_b(out_b), .out_c(out_c)
    );

    typedef struct { longint d; longint q; string tag; } fwd_item_t;
    typedef struct { longint a; longint b; longint c; string tag; } inv_item_t;
    fwd_item_t fq[$];
    inv_item_t iq[$];

    int errors = 0;
    int checks = 0;
    bit prev_acc = 1'b0;
    int held = 1;
    bit done = 1'b0;

    function automatic int norm_fmt(input int f);
        return (f == 0) ? 1 : f;
    endfunction

    task automatic step(input bit fv, input int fmt, input longint a, input longint b,
                        input longint c, input longint s, input bit iv,
                        input longint d, input longint q, input string tag);
        fwd_item_t fi;
        inv_item_t ii;
        int eff;
        longint ae;
        fwd_valid = fv; fmt_sel = fmt[1:0];
        ph_a = a[IN_W-1:0]; ph_b = b[IN_W-1:0]; ph_c = c[IN_W-1:0]; ph_s = s[IN_W-1:0];
        rot_valid = iv; rot_d = d[OW-1:0]; rot_q = q[OW-1:0];
        if (fv) begin
            eff = prev_acc ? held : norm_fmt(fmt);
            held = eff;
            if (eff == 1) begin
                fi.d = a; fi.q = s;
            end else begin
                ae = (eff == 3) ? -(b + c) : a;
                fi.d = ((2 * ae - b - c) * 21845) >>> 16;
                fi.q = ((b - c) * 37837) >>> 16;
            end
            fi.tag = tag;
            fq.push_back(fi);
        end
        prev_acc = fv;
        if (iv) begin
            ii.a = d;
            ii.b = ((-d * 32768) - q * 56756) >>> 16;
            ii.c = ((-d * 32768) + q * 56756) >>> 16;
            ii.tag = tag;
            iq.push_back(ii);
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 1, 0, 0, 0, 0, 0, 0, 0, "idle");
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dq_valid) begin
                checks++;
                if (fq.size() == 0) begin
                    errors++;
                    $display("FAIL R2: dq_valid with nothing expected, d=%0d", d_out);
                end else begin
                    fwd_item_t e;
                    e = fq.pop_front();
                    if (longint'(d_out) != e.d || longint'(q_out) != e.q) begin
                        errors++;
                        $display("FAIL %s: d/q actual %0d/%0d expected %0d/%0d",
                                 e.tag, d_out, q_out, e.d, e.q);
                    end
                end
            end
            if (abc_valid) begin
                checks++;
                if (iq.size() == 0) begin
                    errors++;
                    $display("FAIL R8: abc_valid with nothing expected, a=%0d", out_a);
                end else begin
                    inv_item_t e;
                    e = iq.pop_front();
                    if (longint'(out_a) != e.a || longint'(out_b) != e.b || longint'(out_c) != e.c) begin
                        errors++;
                        $display("FAIL %s: a/b/c actual %0d/%0d/%0d expected %0d/%0d/%0d",
                                 e.tag, out_a, out_b, out_c, e.a, e.b, e.c);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (dq_valid !== 1'b0 || abc_valid !== 1'b0 || d_out !== '0 || q_out !== '0 ||
            out_a !== '0 || out_b !== '0 || out_c !== '0) begin
            errors++;
            $display("FAIL R1: outputs actual %0b/%0b/%0d expected 0/0/0", dq_valid, abc_valid, d_out);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (dq_valid !== 1'b0 || abc_valid !== 1'b0 || out_b !== '0) begin
            errors++;
            $display("FAIL R1: after release actual %0b/%0b expected 0/0", dq_valid, abc_valid);
        end

        // R3: orthogonal pass-through, ph_b/ph_c ignored
        step(1, 1, 12345, 999, -999, -2222, 0, 0, 0, "R3");
        idle(1);
        step(1, 1, -32768, 32767, -32768, 32767, 0, 0, 0, "R3");
        idle(1);
        // R6: reserved code acts as orthogonal
        step(1, 0, 777, -5, 5, -31000, 0, 0, 0, "R6");
        idle(1);
        // R4: three inputs, ph_s ignored
        step(1, 2, 20000, -10000, -10000, 4321, 0, 0, 0, "R4");
        idle(1);
        step(1, 2, -32768, 32767, 32767, -1, 0, 0, 0, "R4");
        idle(1);
        step(1, 2, 0, 28377, -28377, 100, 0, 0, 0, "R4");
        idle(1);
        step(1, 2, 3, -7, 11, 0, 0, 0, 0, "R4");
        idle(1);
        // R5: two inputs, ph_a and ph_s ignored
        step(1, 3, 31111, -10000, -10000, 555, 0, 0, 0, "R5");
        idle(1);
        step(1, 3, -1, 32767, 32767, 9, 0, 0, 0, "R5");
        idle(1);
        step(1, 3, 12, -32768, -32768, -9, 0, 0, 0, "R5");
        idle(1);
        // R7: back-to-back, later select codes ignored while loading
        step(1, 2, 100, 200, -300, 50, 0, 0, 0, "R7");
        step(1, 1, 1000, -2000, 500, 60, 0, 0, 0, "R7");
        step(1, 3, 4000, 1500, -700, 70, 0, 0, 0, "R7");
        idle(1);
        step(1, 1, 4000, 1500, -700, 70, 0, 0, 0, "R7");
        idle(3);
        // R8: inverse conversion
        step(0, 1, 0, 0, 0, 0, 1, 65536, 0, "R8");
        step(0, 1, 0, 0, 0, 0, 1, -131072, 131071, "R8");
        step(0, 1, 0, 0, 0, 0, 1, 131071, -131072, "R8");
        idle(1);
        step(0, 1, 0, 0, 0, 0, 1, -3, 7, "R8");
        idle(3);
        // R9: both paths in the same cycle
        step(1, 2, 30000, -15000, -15000, 0, 1, 20000, -12000, "R9");
        step(1, 2, -100, 50, 50, 0, 1, -1, 1, "R9");
        idle(1);
        step(1, 3, 0, 8000, -16000, 0, 1, 8000, 13856, "R9");
        step(1, 1, 5, 6, 7, 8, 1, -99999, 54321, "R9");
        idle(4);

        done = 1'b1;
        checks++;
        if (fq.size() != 0 || iq.size() != 0) begin
            errors++;
            $display("FAIL R2: pending results actual %0d/%0d expected 0/0", fq.size(), iq.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule